// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-clock static RAM with flow-through reads. The array is organised in byte lanes. Each lane holds eight data bits and one parity bit. The number of words and the number of lanes are parameters. Every address, strobe, chip-select and write input is captured on the rising clock edge. Read data then comes straight from the array at the registered address, with no output register, so it is valid in the same cycle that follows the edge.

Two active-low address strobes start a burst. The processor strobe is gated by the primary chip enable and always starts a read. A write to the loaded address can follow on the next edge as a suspend-write. The controller strobe is not gated by the primary enable, and it can start either a read or a write. When neither strobe is active, an advance input steps a 2-bit burst counter in either linear or interleaved order. If the advance input is left high, the cycle holds the current address as a wait state.

A sleep input powers the array down two edges after it is raised and releases it two edges after it falls. The array contents are kept. The data bus is split into an input port, an output port and an output-drive qualifier.

Top module: `sburst_ram`

## Requirements
- R1: After reset the output-drive qualifier `dout_oe_o` is 0 and no burst is active, even with `oe_n_i` low.
- R2: A read cycle (begin, continue or suspend) shows the word at the registered address on `dout_o`, and `dout_oe_o` is 1 in the cycle after that edge when `oe_n_i` is low.
- R3: With `wall_n_i` low on a write cycle, every lane is written, whatever the values of `wbyte_n_i` and `lane_n_i`.
- R4: With `wall_n_i` high and `wbyte_n_i` low, each lane l whose `lane_n_i[l]` is low is written. Lane l occupies data bits [9l+8:9l], and its parity bit is bit 9l+8. Lanes whose strobe is high keep their old contents.
- R5: With `wall_n_i` and `wbyte_n_i` both high, or with every `lane_n_i` bit high, the cycle is a read, and the array is unchanged.
- R6: A processor-strobe edge (`pstb_n_i` low, `ce_n_i` low) always loads the address and reads, even when the write controls are active. Write controls active on the next edge, with `adv_n_i` high and no strobe, write that same address.
- R7: While `ce_n_i` is high, `pstb_n_i` is ignored, and the cycle acts as a continue or suspend cycle. A controller strobe (`cstb_n_i` low) with `ce_n_i` high gives a deselect cycle.
- R8: On a strobe edge, the secondary selects are checked. If `sel_hi_i` is low or `sel_lo_n_i` is high, the edge is a deselect: the output floats from the next cycle. A valid strobe on the very next edge reselects at once.
- R9: `oe_n_i` acts without a clock. `dout_oe_o` can be 1 only while `oe_n_i` is low, and it follows `oe_n_i` within the same cycle.
- R10: If `sleep_i` is first seen high at edge k, edges k and k+1 still act on their inputs, and edges from k+2 on are ignored. The output floats from edge k+1 until sleep ends. If `sleep_i` is first seen low at edge m, edges m and m+1 are ignored and edge m+2 acts. Array contents survive sleep.
- R11: A cycle with `adv_n_i` high and no active strobe, while a burst is active, keeps the current address. It repeats a read, or writes to that same address.
- R12: With `adv_n_i` low and no active strobe, the burst offset after k steps from a loaded offset b is (b+k) mod 4 when `linear_i` is 1, and b XOR k when `linear_i` is 0. The upper address bits stay fixed, and each step also reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Power-down request, two-edge latency |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| ce_n_i | input | 1 | Primary chip enable, active low; gates the processor strobe |
| sel_hi_i | input | 1 | Secondary select, active high, checked on strobe edges |
| sel_lo_n_i | input | 1 | Secondary select, active low, checked on strobe edges |
| pstb_n_i | input | 1 | Processor address strobe, active low |
| cstb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| wall_n_i | input | 1 | Write-all-lanes, active low |
| wbyte_n_i | input | 1 | Lane-write qualifier, active low |
| lane_n_i | input | BYTES | Per-lane write strobes, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| addr_i | input | ADDR_W | Word address; the low two bits seed the burst offset |
| din_i | input | 9*BYTES | Write data, lane l at bits [9l+8:9l] |
| dout_o | output | 9*BYTES | Read data from the registered address |
| dout_oe_o | output | 1 | High when dout_o should be driven onto the bus |

## Verification
Every synchronous effect is due one edge after its stimulus. An address loaded, stepped or held at edge n shows its word on `dout_o` 1 ns after edge n. A word written at edge n can be read by a strobe at edge n+1. For each step, the bench drives inputs 1 ns after a rising edge and samples 1 ns after the next one. The output-enable checks sample 1 ns after `oe_n_i` changes, with no edge in between. Sleep checks count edges from the first edge that sees the new `sleep_i` level, and they expect effects at edges k+1, k+2, m+1 and m+2 exactly.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int LANE_W = 9;   // eight data bits plus one parity bit

    typedef enum logic [2:0] {
        OP_NONE,    // ignored edge or no activity while deselected
        OP_DESEL,   // strobe with failing select
        OP_LOAD,    // begin burst at external address
        OP_STEP,    // continue burst at next address
        OP_HOLD     // suspend: repeat current address
    } op_e;

    typedef struct packed {
        op_e  op;
        logic wr;
    } cyc_t;

    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       linear);
        logic [1:0] sum;
        sum = base + cnt;
        return linear ? sum : (base ^ cnt);
    endfunction

    function automatic logic holds_addr(input op_e op);
        return (op == OP_LOAD) || (op == OP_STEP) || (op == OP_HOLD);
    endfunction

endpackage

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
    import sbr_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_i,
    input  logic             ce_n_i,
    input  logic             sel_hi_i,
    input  logic             sel_lo_n_i,
    input  logic             pstb_n_i,
    input  logic             cstb_n_i,
    input  logic             adv_n_i,
    input  logic             wall_n_i,
    input  logic             wbyte_n_i,
    input  logic [BYTES-1:0] lane_n_i,
    output cyc_t             cyc_o,
    output logic [BYTES-1:0] wmask_o,
    output logic             rd_q_o,
    output logic             sel_q_o,
    output logic             slp1_q_o,
    output logic             slp2_q_o
);

    logic wr_req;
    logic sel_ok;
    logic act_d;

    always_comb begin
        wr_req = !wall_n_i || (!wbyte_n_i && !(&lane_n_i));
        sel_ok = sel_hi_i && !sel_lo_n_i;
        cyc_o  = '{op: OP_NONE, wr: 1'b0};
        if (!slp2_q_o) begin
            if (!pstb_n_i && !ce_n_i) begin
                cyc_o.op = sel_ok ? OP_LOAD : OP_DESEL;
            end else if (!cstb_n_i) begin
                if (!ce_n_i && sel_ok) begin
                    cyc_o.op = OP_LOAD;
                    cyc_o.wr = wr_req;
                end else begin
                    cyc_o.op = OP_DESEL;
                end
            end else if (sel_q_o) begin
                cyc_o.op = adv_n_i ? OP_HOLD : OP_STEP;
                cyc_o.wr = wr_req;
            end
        end
        act_d = holds_addr(cyc_o.op);
    end

    always_comb begin
        if (!cyc_o.wr)
            wmask_o = '0;
        else if (!wall_n_i)
            wmask_o = '1;
        else
            wmask_o = ~lane_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slp1_q_o <= 1'b0;
            slp2_q_o <= 1'b0;
            sel_q_o  <= 1'b0;
            rd_q_o   <= 1'b0;
        end else begin
            slp1_q_o <= sleep_i;
            slp2_q_o <= slp1_q_o;
            sel_q_o  <= act_d;
            rd_q_o   <= act_d && !cyc_o.wr;
        end
    end

endmodule

// File: rtl/sbr_burst.sv
module sbr_burst
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] nxt_addr_o
);

    logic [ADDR_W-1:2] hi_q;
    logic [1:0]        base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_inc;

    always_comb begin
        cnt_inc    = cnt_q + 2'd1;
        cur_addr_o = {hi_q, burst_low(base_q, cnt_q, linear_i)};
        case (op_i)
            OP_LOAD: nxt_addr_o = addr_i;
            OP_STEP: nxt_addr_o = {hi_q, burst_low(base_q, cnt_inc, linear_i)};
            default: nxt_addr_o = cur_addr_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (op_i == OP_LOAD) begin
            hi_q   <= addr_i[ADDR_W-1:2];
            base_q <= addr_i[1:0];
            cnt_q  <= '0;
        end else if (op_i == OP_STEP) begin
            cnt_q  <= cnt_inc;
        end
    end

endmodule

// File: rtl/sbr_array.sv
module sbr_array
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic                      clk,
    input  logic [BYTES-1:0]          we_i,
    input  logic [ADDR_W-1:0]         waddr_i,
    input  logic [BYTES*LANE_W-1:0]   wdata_i,
    input  logic [ADDR_W-1:0]         raddr_i,
    output logic [BYTES*LANE_W-1:0]   rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g])
                mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
    end

endmodule

// File: rtl/sburst_ram.sv
module sburst_ram
    import sbr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    localparam int DATA_W = BYTES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic              oe_n_i,
    input  logic              ce_n_i,
    input  logic              sel_hi_i,
    input  logic              sel_lo_n_i,
    input  logic              pstb_n_i,
    input  logic              cstb_n_i,
    input  logic              adv_n_i,
    input  logic              wall_n_i,
    input  logic              wbyte_n_i,
    input  logic [BYTES-1:0]  lane_n_i,
    input  logic              linear_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dout_oe_o
);

    cyc_t              cyc;
    logic [BYTES-1:0]  wmask;
    logic              rd_q;
    logic              sel_q;
    logic              sleep_s1;
    logic              pwr_down;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] nxt_addr;

    sbr_ctrl #(.BYTES(BYTES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sleep_i    (sleep_i),
        .ce_n_i     (ce_n_i),
        .sel_hi_i   (sel_hi_i),
        .sel_lo_n_i (sel_lo_n_i),
        .pstb_n_i   (pstb_n_i),
        .cstb_n_i   (cstb_n_i),
        .adv_n_i    (adv_n_i),
        .wall_n_i   (wall_n_i),
        .wbyte_n_i  (wbyte_n_i),
        .lane_n_i   (lane_n_i),
        .cyc_o      (cyc),
        .wmask_o    (wmask),
        .rd_q_o     (rd_q),
        .sel_q_o    (sel_q),
        .slp1_q_o   (sleep_s1),
        .slp2_q_o   (pwr_down)
    );

    sbr_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .op_i       (cyc.op),
        .linear_i   (linear_i),
        .addr_i     (addr_i),
        .cur_addr_o (cur_addr),
        .nxt_addr_o (nxt_addr)
    );

    sbr_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
        .clk     (clk),
        .we_i    (wmask),
        .waddr_i (nxt_addr),
        .wdata_i (din_i),
        .raddr_i (cur_addr),
        .rdata_o (dout_o)
    );

    assign dout_oe_o = rd_q && !oe_n_i && !pwr_down;

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              oe_n_i,
    input logic              ce_n_i,
    input logic              sel_hi_i,
    input logic              sel_lo_n_i,
    input logic              pstb_n_i,
    input logic              cstb_n_i,
    input logic              adv_n_i,
    input logic              dout_oe_o,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              sel_q,
    input logic              sleep_s1,
    input logic              pwr_down
);

    AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
        dout_oe_o |-> !oe_n_i);  // R9

    AST_SLEEP_FLOATS: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> !dout_oe_o);  // R10

    AST_SLEEP_FREEZES_ADDR: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> $stable(cur_addr));  // R10

    AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (rst)
        (!cstb_n_i && !(sel_hi_i && !sel_lo_n_i) && !pwr_down) |=> !dout_oe_o);  // R8

    AST_PROC_STROBE_READS: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n_i && !ce_n_i && sel_hi_i && !sel_lo_n_i && !pwr_down && !sleep_s1)
        |=> (dout_oe_o == !oe_n_i));  // R6

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sel_q && cstb_n_i && (pstb_n_i || ce_n_i) && adv_n_i && !pwr_down)
        |=> $stable(cur_addr));  // R11

endmodule

bind sburst_ram sbr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .oe_n_i     (oe_n_i),
    .ce_n_i     (ce_n_i),
    .sel_hi_i   (sel_hi_i),
    .sel_lo_n_i (sel_lo_n_i),
    .pstb_n_i   (pstb_n_i),
    .cstb_n_i   (cstb_n_i),
    .adv_n_i    (adv_n_i),
    .dout_oe_o  (dout_oe_o),
    .cur_addr   (cur_addr),
    .sel_q      (sel_q),
    .sleep_s1   (sleep_s1),
    .pwr_down   (pwr_down)
);

// File: tb/tb_sburst_ram.sv
`timescale 1ns/1ps
module tb_sburst_ram;

    localparam int AW = 6;
    localparam int NB = 2;
    localparam int DW = NB * 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          sleep_i, oe_n_i, ce_n_i, sel_hi_i, sel_lo_n_i;
    logic          pstb_n_i, cstb_n_i, adv_n_i, wall_n_i, wbyte_n_i;
    logic [NB-1:0] lane_n_i;
    logic          linear_i;
    logic [AW-1:0] addr_i;
    logic [DW-1:0] din_i;
    logic [DW-1:0] dout_o;
    logic          dout_oe_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] model [DEPTH];

    always #5 clk = ~clk;

    sburst_ram #(.ADDR_W(AW), .BYTES(NB)) dut (.*);

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 1021 + salt * 7919 + 341);
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [NB-1:0] mask);
        logic [DW-1:0] r;
        r = old_w;
        for (int l = 0; l < NB; l++)
            if (mask[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        return r;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic psn, input logic csn, input logic advn,
                         input logic cen, input logic shi, input logic slon,
                         input logic wan, input logic wbn, input logic [NB-1:0] ln,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        pstb_n_i = psn;  cstb_n_i = csn;  adv_n_i = advn;
        ce_n_i = cen;    sel_hi_i = shi;  sel_lo_n_i = slon;
        wall_n_i = wan;  wbyte_n_i = wbn; lane_n_i = ln;
        addr_i = a;      din_i = d;
        tick();
    endtask

    task automatic rd_start(input logic [AW-1:0] a);
        drive(1, 0, 1, 0, 1, 0, 1, 1, 2'b11, a, '0);
    endtask

    task automatic wr_start(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic wan, input logic wbn, input logic [NB-1:0] ln);
        drive(1, 0, 1, 0, 1, 0, wan, wbn, ln, a, d);
    endtask

    task automatic idle(input logic advn);
        drive(1, 1, advn, 0, 1, 0, 1, 1, 2'b11, '0, '0);
    endtask

    task automatic expect_read(input logic [AW-1:0] a, input string req);
        check(dout_oe_o === 1'b1 && dout_o === model[a], req,
              {dout_oe_o, dout_o[DW-2:0]}, model[a]);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        logic [DW-1:0] d;
        rst = 1'b1; sleep_i = 1'b0; oe_n_i = 1'b0; linear_i = 1'b1;
        pstb_n_i = 1; cstb_n_i = 1; adv_n_i = 1; ce_n_i = 0; sel_hi_i = 1;
        sel_lo_n_i = 0; wall_n_i = 1; wbyte_n_i = 1; lane_n_i = '1;
        addr_i = '0; din_i = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: floated after reset even with output enable low
        check(dout_oe_o === 1'b0, "R1", {{(DW-1){1'b0}}, dout_oe_o}, '0);

        // R3: write-all overrides lane controls (lanes high, lane qualifier high)
        for (int a = 0; a < DEPTH; a++) begin
            wr_start(AW'(a), pat(a, 0), 1'b0, 1'b1, 2'b11);
            model[a] = pat(a, 0);
            check(dout_oe_o === 1'b0, "R3 write cycle floats", {17'd0, dout_oe_o}, '0);
        end
        // R2: flow-through read of every word
        for (int a = 0; a < DEPTH; a++) begin
            rd_start(AW'(a));
            expect_read(AW'(a), "R2/R3");
        end

        // R4: per-lane writes including parity bits
        for (int a = 5; a < 8; a++) begin
            logic [NB-1:0] ln;
            ln = (a == 5) ? 2'b10 : (a == 6) ? 2'b01 : 2'b00;
            d  = {DW{1'b1}} ^ pat(a, 3);
            wr_start(AW'(a), d, 1'b1, 1'b0, ln);
            model[a] = merge(model[a], d, ~ln);
        end
        for (int a = 5; a < 8; a++) begin
            rd_start(AW'(a));
            expect_read(AW'(a), "R4");
        end

        // R5: lane qualifier high, or all lanes high, means read
        wr_start(6'd8, pat(8, 9), 1'b1, 1'b1, 2'b00);
        expect_read(6'd8, "R5 qualifier high");
        wr_start(6'd9, pat(9, 9), 1'b1, 1'b0, 2'b11);
        expect_read(6'd9, "R5 all lanes high");

        // R6: processor strobe reads despite write controls; write on next edge
        d = pat(9, 5);
        drive(0, 1, 1, 0, 1, 0, 1'b0, 1'b1, 2'b11, 6'd9, d);
        expect_read(6'd9, "R6 strobe edge reads old word");
        drive(1, 1, 1, 0, 1, 0, 1'b0, 1'b1, 2'b11, 6'd20, d);
        model[9] = d;
        check(dout_oe_o === 1'b0, "R6 write cycle floats", {17'd0, dout_oe_o}, '0);
        idle(1'b1);
        expect_read(6'd9, "R6/R11 suspend write landed");

        // R7: primary enable high blocks the processor strobe
        rd_start(6'd10);
        drive(0, 1, 1, 1, 1, 0, 1, 1, 2'b11, 6'd20, '0);
        expect_read(6'd10, "R7 blocked strobe holds");
        drive(1, 0, 1, 1, 1, 0, 1, 1, 2'b11, 6'd21, '0);
        check(dout_oe_o === 1'b0, "R7 controller strobe deselects", {17'd0, dout_oe_o}, '0);

        // R8: secondary selects and single-cycle deselect
        rd_start(6'd11);
        drive(1, 0, 1, 0, 1'b0, 0, 1, 1, 2'b11, 6'd12, '0);
        check(dout_oe_o === 1'b0, "R8 high select low", {17'd0, dout_oe_o}, '0);
        rd_start(6'd12);
        expect_read(6'd12, "R8 reselect next edge");
        drive(0, 1, 1, 0, 1, 1'b1, 1, 1, 2'b11, 6'd13, '0);
        check(dout_oe_o === 1'b0, "R8 low select high", {17'd0, dout_oe_o}, '0);

        // R9: asynchronous output enable
        rd_start(6'd14);
        oe_n_i = 1'b1; #1;
        check(dout_oe_o === 1'b0, "R9 disable", {17'd0, dout_oe_o}, '0);
        oe_n_i = 1'b0; #1;
        expect_read(6'd14, "R9 enable");

        // R11: suspend repeats the address
        rd_start(6'd16);
        idle(1'b1);
        expect_read(6'd16, "R11 wait 1");
        idle(1'b1);
        expect_read(6'd16, "R11 wait 2");

        // R12: burst order sweep, both modes, all offsets
        for (int lin = 0; lin < 2; lin++) begin
            linear_i = lin[0];
            for (int off = 0; off < 4; off++) begin
                rd_start(AW'(32 + off));
                expect_read(AW'(32 + off), "R12 load");
                for (int k = 1; k < 4; k++) begin
                    int lo;
                    lo = lin ? ((off + k) % 4) : (off ^ k);
                    idle(1'b0);
                    expect_read(AW'(32 + lo), "R12 step");
                end
            end
        end
        // R12: burst writes, linear from offset 2 and interleaved from offset 1
        for (int lin = 0; lin < 2; lin++) begin
            int base;
            int off;
            linear_i = lin[0];
            base = lin ? 40 : 44;
            off  = lin ? 2 : 1;
            for (int k = 0; k < 4; k++) begin
                int lo;
                lo = lin ? ((off + k) % 4) : (off ^ k);
                d = pat(base + lo, 11);
                if (k == 0) wr_start(AW'(base + off), d, 1'b0, 1'b1, 2'b11);
                else drive(1, 1, 0, 0, 1, 0, 1'b0, 1'b1, 2'b11, '0, d);
                model[base + lo] = d;
            end
            for (int k = 0; k < 4; k++) begin
                rd_start(AW'(base + k));
                expect_read(AW'(base + k), "R12 burst write");
            end
        end
        linear_i = 1'b1;

        // R10: output floats from the second sleep edge
        rd_start(6'd16);
        sleep_i = 1'b1;
        idle(1'b1);
        expect_read(6'd16, "R10 edge k still active");
        idle(1'b1);
        check(dout_oe_o === 1'b0, "R10 floats after k+1", {17'd0, dout_oe_o}, '0);
        sleep_i = 1'b0;
        idle(1'b1); idle(1'b1); idle(1'b1);
        // R10: entry and exit latency measured by writes
        sleep_i = 1'b1;
        wr_start(6'd49, pat(49, 21), 1'b0, 1'b1, 2'b11); model[49] = pat(49, 21);
        wr_start(6'd50, pat(50, 21), 1'b0, 1'b1, 2'b11); model[50] = pat(50, 21);
        wr_start(6'd51, pat(51, 21), 1'b0, 1'b1, 2'b11);
        idle(1'b1);
        sleep_i = 1'b0;
        wr_start(6'd52, pat(52, 21), 1'b0, 1'b1, 2'b11);
        wr_start(6'd53, pat(53, 21), 1'b0, 1'b1, 2'b11);
        wr_start(6'd54, pat(54, 21), 1'b0, 1'b1, 2'b11); model[54] = pat(54, 21);
        for (int a = 49; a < 55; a++) begin
            rd_start(AW'(a));
            expect_read(AW'(a), "R10 latency");
        end
        rd_start(6'd0);
        expect_read(6'd0, "R10 retention");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule